// File: doc/BRIEF.md
# Parallel NOR Flash Bus Controller

This block sits on the synchronous side of a chip and drives an asynchronous 16-bit parallel NOR flash module. The module has two banks, each with its own active-low select. Each bank is built from two 8-bit chips, one per byte lane. A host issues read, word-program, sector-erase and full-bank-erase requests on a valid/ready port. The controller turns each request into select, output-enable, write-enable, address and data waveforms. Every setup, pulse, access and recovery interval in those waveforms is a whole number of clock cycles, set by a parameter.

A read is a single access, and its data is returned with a one-cycle `rd_valid` strobe. A program or erase is a train of unlock and command writes. The same command byte goes to both byte lanes. After the last write the controller reads the target word again and again until bit 7 of every lane shows its final value. It then pulses `done`. If that never happens within `POLL_MAX` polls, it pulses `err` instead.

The state machine has these states: IDLE (accept), RD_ACC (read access), RD_FLOAT (bus release after a read), WR_SETUP, WR_PULSE and WR_HOLD (one command write), PL_ACC (status read) and PL_FLOAT (release after a status read). Transitions:
- IDLE→RD_ACC on a read request, and IDLE→WR_SETUP on a program or erase request.
- RD_ACC→RD_FLOAT→IDLE for a read.
- WR_SETUP→WR_PULSE→WR_HOLD for each write. From WR_HOLD the machine goes back to WR_SETUP while command steps remain, and to PL_ACC after the last one.
- PL_ACC→PL_FLOAT for each status read. PL_FLOAT→PL_ACC while polls remain and none has matched. PL_FLOAT→IDLE on a match (done) or when the poll budget runs out (error).

Top module: `nor_bus_ctrl`

## Requirements
- R1: A read holds the addressed bank select and `fl_oe_n` low, with `fl_we_n` high, for exactly `T_ACC` cycles. The word on `fl_dq_in` at the end of that window appears on `rd_data`. `rd_valid` is high for exactly one cycle, `T_ACC` cycles after the accepting edge.
- R2: `fl_dq_oe` is never high while `fl_oe_n` is low. After any read ends, `fl_oe_n` and `fl_we_n` both stay high for at least `T_DF` cycles before either falls again.
- R3: While `fl_we_n` is low, the bank select is low, `fl_oe_n` is high and `fl_dq_oe` is high. `fl_addr` and `fl_dq_out` do not change during the pulse.
- R4: Each `fl_we_n` low pulse lasts exactly `T_WP` cycles. Within one command train, `fl_we_n` stays high for exactly `T_WPH + T_AS` cycles between pulses.
- R5: A program (op 1) issues four writes as (word address, data): (0x555, 0xAAAA), (0x2AA, 0x5555), (0x555, 0xA0A0), and finally (request address, request data).
- R6: An erase issues six writes: (0x555, 0xAAAA), (0x2AA, 0x5555), (0x555, 0x8080), (0x555, 0xAAAA), (0x2AA, 0x5555). The sixth write is (request address, 0x3030) for a sector erase (op 2) and (0x555, 0x1010) for a full-bank erase (op 3). A sector is a word-address range sharing address bits 16:14.
- R7: After the last write, status reads go to the request address. Polling stops at the first read where bits 7 and 15 equal the programmed data's bits 7 and 15 (for a program) or are both 1 (for an erase). Then `done` pulses for one cycle.
- R8: If `POLL_MAX` status reads pass without a match, `err` pulses for one cycle and `done` stays low.
- R9: At most one bank select is low at any time. It is the one named by request address bit 17 (0 selects `fl_cs_n[0]`).
- R10: Out of reset and whenever no request is in progress, `req_ready` is high, both selects, `fl_oe_n` and `fl_we_n` are high and `fl_dq_oe` is low. `req_ready` is low from the accepting edge until the request finishes. Read is op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken on valid and ready |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 bank erase |
| req_addr | input | AW+BW (18) | Bit 17 bank, bits 16:0 word address |
| req_wdata | input | DW (16) | Word to program |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW (16) | Read data |
| done | output | 1 | One-cycle program/erase completion pulse |
| err | output | 1 | One-cycle poll timeout pulse |
| fl_cs_n | output | NBANK (2) | Active-low bank selects |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_we_n | output | 1 | Active-low write enable |
| fl_addr | output | AW (17) | Flash word address |
| fl_dq_out | output | DW (16) | Write data to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW (16) | Data from flash |

## Verification
A wrong step counter shows up as a misplaced or missing command write. It is visible at the first rising edge of `fl_we_n` that carries the wrong address or data, or as a write count other than four or six. A timer loaded with the wrong interval shows as a pulse, access or gap of the wrong length, and this is caught on the very edge where the strobe returns high. A mistake in the poll compare or the poll counter shows as `done` arriving after the wrong number of status reads, or as `err` in place of `done`. This is caught when the request finishes.

// File: rtl/nor_bus_pkg.sv
package nor_bus_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_PROG       = 2'd1,
        OP_SECT_ERASE = 2'd2,
        OP_BANK_ERASE = 2'd3
    } nor_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_PL_ACC,
        ST_PL_FLOAT
    } nor_state_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/nor_cycle_timer.sv
module nor_cycle_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_bus_pkg::*;
#(
    parameter int            AW        = 17,
    parameter int            DW        = 16,
    parameter logic [AW-1:0] UNLK_A1   = AW'('h555),
    parameter logic [AW-1:0] UNLK_A2   = AW'('h2AA),
    parameter logic [7:0]    UNLK_D1   = 8'hAA,
    parameter logic [7:0]    UNLK_D2   = 8'h55,
    parameter logic [7:0]    CMD_PROG  = 8'hA0,
    parameter logic [7:0]    CMD_ERASE = 8'h80,
    parameter logic [7:0]    CMD_SECT  = 8'h30,
    parameter logic [7:0]    CMD_BANK  = 8'h10
) (
    input  nor_op_e           op,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     cmd_addr,
    output logic [DW-1:0]     cmd_data,
    output logic              last
);
    localparam int LANES = DW / 8;

    logic [7:0] cmd_byte;
    logic       use_word;

    always_comb begin
        cmd_addr = UNLK_A1;
        cmd_byte = 8'h00;
        use_word = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                3'd0:    cmd_byte = UNLK_D1;
                3'd1:    begin cmd_addr = UNLK_A2; cmd_byte = UNLK_D2; end
                3'd2:    cmd_byte = CMD_PROG;
                default: begin cmd_addr = tgt_addr; use_word = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0, 3'd3: cmd_byte = UNLK_D1;
                3'd1, 3'd4: begin cmd_addr = UNLK_A2; cmd_byte = UNLK_D2; end
                3'd2:       cmd_byte = CMD_ERASE;
                default: begin
                    if (op == OP_SECT_ERASE) begin
                        cmd_addr = tgt_addr;
                        cmd_byte = CMD_SECT;
                    end else begin
                        cmd_byte = CMD_BANK;
                    end
                end
            endcase
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cmd_data[8*l +: 8] = use_word ? tgt_data[8*l +: 8] : cmd_byte;
    end

    assign last = (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] rd_flag,
    input  logic [LANES-1:0] exp_flag,
    output logic             match
);
    logic [LANES-1:0] lane_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_ok[l] = (rd_flag[l] == exp_flag[l]);
    end

    assign match = &lane_ok;
endmodule

// File: rtl/nor_bus_ctrl.sv
module nor_bus_ctrl
    import nor_bus_pkg::*;
#(
    parameter int            AW        = 17,
    parameter int            DW        = 16,
    parameter int            NBANK     = 2,
    parameter int            T_ACC     = 5,
    parameter int            T_DF      = 2,
    parameter int            T_AS      = 1,
    parameter int            T_WP      = 3,
    parameter int            T_WPH     = 2,
    parameter int            POLL_MAX  = 256,
    parameter logic [AW-1:0] UNLK_A1   = AW'('h555),
    parameter logic [AW-1:0] UNLK_A2   = AW'('h2AA),
    parameter logic [7:0]    UNLK_D1   = 8'hAA,
    parameter logic [7:0]    UNLK_D2   = 8'h55,
    parameter logic [7:0]    CMD_PROG  = 8'hA0,
    parameter logic [7:0]    CMD_ERASE = 8'h80,
    parameter logic [7:0]    CMD_SECT  = 8'h30,
    parameter logic [7:0]    CMD_BANK  = 8'h10,
    localparam int           BW        = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [AW+BW-1:0] req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             err,
    output logic [NBANK-1:0] fl_cs_n,
    output logic             fl_oe_n,
    output logic             fl_we_n,
    output logic [AW-1:0]    fl_addr,
    output logic [DW-1:0]    fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [DW-1:0]    fl_dq_in
);
    localparam int LANES = DW / 8;
    localparam int TW    = $clog2(T_ACC + T_DF + T_AS + T_WP + T_WPH + 1);
    localparam int PW    = $clog2(POLL_MAX + 1);

    nor_state_e        state, nxt;
    nor_op_e           op_q;
    logic [AW-1:0]     addr_q;
    logic [BW-1:0]     bank_q;
    logic [DW-1:0]     wdata_q;
    logic [STEP_W-1:0] step_q;
    logic [PW-1:0]     poll_cnt;
    logic              hit_q;
    logic              cs_act;
    logic              t_load, t_exp;
    logic [TW-1:0]     t_val;
    logic [AW-1:0]     cmd_addr;
    logic              cmd_last;
    logic [LANES-1:0]  rd_flag, exp_flag;
    logic              poll_match;

    nor_cycle_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    nor_cmd_seq #(
        .AW(AW), .DW(DW), .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2),
        .UNLK_D1(UNLK_D1), .UNLK_D2(UNLK_D2), .CMD_PROG(CMD_PROG),
        .CMD_ERASE(CMD_ERASE), .CMD_SECT(CMD_SECT), .CMD_BANK(CMD_BANK)
    ) u_cmd (
        .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(wdata_q),
        .cmd_addr(cmd_addr), .cmd_data(fl_dq_out), .last(cmd_last)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_flag
        assign rd_flag[l]  = fl_dq_in[8*l + 7];
        assign exp_flag[l] = (op_q == OP_PROG) ? wdata_q[8*l + 7] : 1'b1;
    end

    nor_poll_eval #(.LANES(LANES)) u_poll (
        .rd_flag(rd_flag), .exp_flag(exp_flag), .match(poll_match)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and interval loading
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                t_load = 1'b1;
                if (nor_op_e'(req_op) == OP_READ) begin
                    nxt = ST_RD_ACC;   t_val = TW'(T_ACC - 1);
                end else begin
                    nxt = ST_WR_SETUP; t_val = TW'(T_AS - 1);
                end
            end
            ST_RD_ACC: if (t_exp) begin
                nxt = ST_RD_FLOAT; t_load = 1'b1; t_val = TW'(T_DF - 1);
            end
            ST_RD_FLOAT: if (t_exp) nxt = ST_IDLE;
            ST_WR_SETUP: if (t_exp) begin
                nxt = ST_WR_PULSE; t_load = 1'b1; t_val = TW'(T_WP - 1);
            end
            ST_WR_PULSE: if (t_exp) begin
                nxt = ST_WR_HOLD; t_load = 1'b1; t_val = TW'(T_WPH - 1);
            end
            ST_WR_HOLD: if (t_exp) begin
                t_load = 1'b1;
                if (cmd_last) begin
                    nxt = ST_PL_ACC;   t_val = TW'(T_ACC - 1);
                end else begin
                    nxt = ST_WR_SETUP; t_val = TW'(T_AS - 1);
                end
            end
            ST_PL_ACC: if (t_exp) begin
                nxt = ST_PL_FLOAT; t_load = 1'b1; t_val = TW'(T_DF - 1);
            end
            ST_PL_FLOAT: if (t_exp) begin
                if (hit_q || poll_cnt == PW'(POLL_MAX)) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt = ST_PL_ACC; t_load = 1'b1; t_val = TW'(T_ACC - 1);
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // strobes decoded from state
    always_comb begin
        cs_act    = 1'b0;
        fl_oe_n   = 1'b1;
        fl_we_n   = 1'b1;
        fl_dq_oe  = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:                  req_ready = 1'b1;
            ST_RD_ACC, ST_PL_ACC:     begin cs_act = 1'b1; fl_oe_n = 1'b0; end
            ST_WR_SETUP, ST_WR_HOLD:  begin cs_act = 1'b1; fl_dq_oe = 1'b1; end
            ST_WR_PULSE:              begin cs_act = 1'b1; fl_dq_oe = 1'b1; fl_we_n = 1'b0; end
            ST_RD_FLOAT, ST_PL_FLOAT: ;
            default: ;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign fl_cs_n[b] = !(cs_act && bank_q == BW'(b));
    end

    assign fl_addr = fl_dq_oe ? cmd_addr : addr_q;

    // request capture, step and poll bookkeeping, host strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_READ; addr_q <= '0; bank_q <= '0; wdata_q <= '0;
            step_q <= '0; poll_cnt <= '0; hit_q <= 1'b0;
            rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q     <= nor_op_e'(req_op);
                    addr_q   <= req_addr[AW-1:0];
                    bank_q   <= req_addr[AW +: BW];
                    wdata_q  <= req_wdata;
                    step_q   <= '0;
                    poll_cnt <= '0;
                    hit_q    <= 1'b0;
                end
                ST_RD_ACC: if (t_exp) begin
                    rd_data  <= fl_dq_in;
                    rd_valid <= 1'b1;
                end
                ST_WR_HOLD: if (t_exp && !cmd_last) step_q <= step_q + 1'b1;
                ST_PL_ACC: if (t_exp) begin
                    hit_q    <= poll_match;
                    poll_cnt <= poll_cnt + 1'b1;
                end
                ST_PL_FLOAT: if (t_exp) begin
                    if (hit_q)                            done <= 1'b1;
                    else if (poll_cnt == PW'(POLL_MAX))   err  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_dq_oe && !fl_oe_n)); // R2
    AST_WE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && fl_dq_oe && !(&fl_cs_n))); // R3
    AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R3
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~fl_cs_n) <= 1); // R9
    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&fl_cs_n && fl_oe_n && fl_we_n && !fl_dq_oe)); // R10
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R1
endmodule

// File: tb/tb_nor_bus_ctrl.sv
module tb_nor_bus_ctrl;
    import nor_bus_pkg::*;

    localparam int CLK_NS = 20;
    localparam int T_ACC = 5, T_DF = 2, T_AS = 1, T_WP = 3, T_WPH = 2;
    localparam int POLL = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid, done, err;
    logic [15:0] rd_data;
    logic [1:0]  fl_cs_n;
    logic        fl_oe_n, fl_we_n, fl_dq_oe;
    logic [16:0] fl_addr;
    logic [15:0] fl_dq_out, fl_dq_in;

    always #(CLK_NS/2) clk = ~clk;

    nor_bus_ctrl #(.POLL_MAX(POLL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in)
    );

    int n_tests = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural flash model ----------------
    typedef struct { int bank; logic [16:0] a; logic [15:0] d; } wr_t;
    wr_t         wlog[$];
    logic [15:0] mem [int];
    int          cur_bank = 0;
    logic [16:0] cur_addr = '0;
    int          wr_len = 0, wr_seen = 0, arm_busy = 0, busy_left = 0, rd_cnt = 0, mode = 0;
    bit          wr_arm = 0;
    logic [15:0] resp = 16'h0;

    function automatic int key(input int b, input logic [16:0] a);
        return b * 131072 + int'(a);
    endfunction

    function automatic logic [15:0] peek(input int b, input logic [16:0] a);
        if (mem.exists(key(b, a))) return mem[key(b, a)];
        return 16'hFFFF;
    endfunction

    always @(posedge fl_we_n) begin
        if (rst_n === 1'b1 && wr_arm) begin
            wr_t e;
            int  kill[$];
            e.bank = cur_bank; e.a = fl_addr; e.d = fl_dq_out;
            wlog.push_back(e);
            wr_seen++;
            if (wr_seen == wr_len) begin
                if (mode == 0) begin
                    mem[key(cur_bank, cur_addr)] = peek(cur_bank, cur_addr) & e.d;
                end else begin
                    foreach (mem[k])
                        if (k / 131072 == cur_bank &&
                            (mode == 2 || ((k % 131072) >> 14) == int'(cur_addr[16:14])))
                            kill.push_back(k);
                    foreach (kill[i]) mem.delete(kill[i]);
                end
                busy_left = arm_busy;
            end
        end
    end

    always @(negedge fl_oe_n) begin
        if (rst_n === 1'b1) begin
            rd_cnt++;
            if (busy_left > 0) begin
                resp = peek(cur_bank, cur_addr) ^ 16'h8080;
                busy_left--;
            end else begin
                resp = peek(cur_bank, cur_addr);
            end
        end
    end

    assign fl_dq_in = (!fl_oe_n && fl_cs_n != 2'b11) ? resp : 16'hDEAD;

    // ---------------- per-cycle bus monitor ----------------
    int          we_low = 0, gap = 0, oe_low = 0, flt = 0;
    bit          had_pulse = 0, seen_read = 0;
    logic [16:0] p_addr;
    logic [15:0] p_dq;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready) had_pulse = 0;
            check(fl_cs_n != 2'b00, "R9 both banks selected", fl_cs_n, 2'b11);
            if (fl_cs_n != 2'b11)
                check(fl_cs_n[cur_bank] == 1'b0 && fl_cs_n[1-cur_bank] == 1'b1,
                      "R9 wrong bank select", fl_cs_n, cur_bank);
            check(!(fl_dq_oe && !fl_oe_n), "R2 drive during output enable", fl_dq_oe, 0);
            if (!fl_we_n) begin
                check(fl_oe_n && fl_dq_oe && fl_cs_n != 2'b11, "R3 write frame",
                      {fl_oe_n, fl_dq_oe, fl_cs_n}, 4'b1100);
                if (we_low > 0)
                    check(fl_addr == p_addr && fl_dq_out == p_dq, "R3 address/data moved in pulse",
                          {fl_addr, fl_dq_out}, {p_addr, p_dq});
                else begin
                    if (had_pulse) check(gap == T_WPH + T_AS, "R4 gap between pulses", gap, T_WPH + T_AS);
                    if (seen_read) check(flt >= T_DF, "R2 recovery before write", flt, T_DF);
                end
                we_low++;
            end else begin
                if (we_low > 0) begin
                    check(we_low == T_WP, "R4 pulse width", we_low, T_WP);
                    had_pulse = 1;
                    gap = 0;
                end
                we_low = 0;
                gap++;
            end
            if (!fl_oe_n) begin
                check(fl_addr == cur_addr, "R7 read address", fl_addr, cur_addr);
                if (oe_low == 0 && seen_read) check(flt >= T_DF, "R2 float time", flt, T_DF);
                oe_low++;
            end else begin
                if (oe_low > 0) begin
                    check(oe_low == T_ACC, "R1 access window", oe_low, T_ACC);
                    seen_read = 1;
                    flt = 0;
                end
                oe_low = 0;
                flt++;
            end
            p_addr = fl_addr;
            p_dq   = fl_dq_out;
        end
    end

    // ---------------- request tasks ----------------
    task automatic issue(input nor_op_e op, input int bank, input logic [16:0] a, input logic [15:0] d, output int n);
        @(negedge clk);
        check(req_ready, "R10 ready when idle", req_ready, 1);
        cur_bank = bank; cur_addr = a;
        req_op = op; req_addr = {bank[0], a}; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 ready low while busy", req_ready, 0);
        n = 1;
        while (!(rd_valid || done || err) && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_read(input int bank, input logic [16:0] a, input logic [15:0] exp, input string tag);
        int n;
        issue(OP_READ, bank, a, 16'h0, n);
        check(rd_valid, {tag, " R1 rd_valid seen"}, rd_valid, 1);
        check(n == T_ACC + 1, {tag, " R1 read latency"}, n, T_ACC + 1);
        check(rd_data == exp, {tag, " R1 read data"}, rd_data, exp);
        @(negedge clk);
        check(!rd_valid, {tag, " R1 rd_valid one cycle"}, rd_valid, 0);
    endtask

    task automatic start_wr(input int len, input int busy, input int m);
        wlog.delete(); wr_seen = 0; wr_len = len; arm_busy = busy; mode = m; rd_cnt = 0; wr_arm = 1;
    endtask

    task automatic cmp_log(input wr_t exp_q[$], input string tag);
        check(wlog.size() == exp_q.size(), {tag, " write count"}, wlog.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < wlog.size())
                check(wlog[i].a == exp_q[i].a && wlog[i].d == exp_q[i].d && wlog[i].bank == exp_q[i].bank,
                      $sformatf("%s write %0d", tag, i), {wlog[i].a, wlog[i].d}, {exp_q[i].a, exp_q[i].d});
    endtask

    function automatic wr_t mk(input int b, input logic [16:0] a, input logic [15:0] d);
        wr_t e; e.bank = b; e.a = a; e.d = d; return e;
    endfunction

    task automatic do_prog(input int bank, input logic [16:0] a, input logic [15:0] d, input int busy, input bit exp_err);
        int  n;
        wr_t q[$];
        start_wr(4, busy, 0);
        issue(OP_PROG, bank, a, d, n);
        q = '{mk(bank, 17'h555, 16'hAAAA), mk(bank, 17'h2AA, 16'h5555), mk(bank, 17'h555, 16'hA0A0), mk(bank, a, d)};
        cmp_log(q, "R5 program");
        if (exp_err) begin
            check(err && !done, "R8 timeout error", {done, err}, 2'b01);
            check(rd_cnt == POLL, "R8 poll count", rd_cnt, POLL);
        end else begin
            check(done && !err, "R7 program done", {done, err}, 2'b10);
            check(rd_cnt == busy + 1, "R7 program poll count", rd_cnt, busy + 1);
        end
        @(negedge clk);
        check(!done && !err, "R7 done/err one cycle", {done, err}, 0);
        wr_arm = 0; busy_left = 0;
    endtask

    task automatic do_erase(input int bank, input logic [16:0] a, input bit whole, input int busy);
        int  n;
        wr_t q[$];
        start_wr(6, busy, whole ? 2 : 1);
        issue(whole ? OP_BANK_ERASE : OP_SECT_ERASE, bank, a, 16'h0, n);
        q = '{mk(bank, 17'h555, 16'hAAAA), mk(bank, 17'h2AA, 16'h5555), mk(bank, 17'h555, 16'h8080),
              mk(bank, 17'h555, 16'hAAAA), mk(bank, 17'h2AA, 16'h5555),
              whole ? mk(bank, 17'h555, 16'h1010) : mk(bank, a, 16'h3030)};
        cmp_log(q, "R6 erase");
        check(done && !err, "R7 erase done", {done, err}, 2'b10);
        check(rd_cnt == busy + 1, "R7 erase poll count", rd_cnt, busy + 1);
        @(negedge clk);
        wr_arm = 0; busy_left = 0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && fl_cs_n == 2'b11 && fl_oe_n && fl_we_n && !fl_dq_oe,
              "R10 reset state", {req_ready, fl_cs_n, fl_oe_n, fl_we_n, fl_dq_oe}, 6'b111110);
        check(!rd_valid && !done && !err, "R10 reset strobes", {rd_valid, done, err}, 0);

        do_read(0, 17'h00123, 16'hFFFF, "erased");
        do_prog(0, 17'h00123, 16'h1234, 3, 0);
        do_read(0, 17'h00123, 16'h1234, "after program");
        do_prog(1, 17'h1F00F, 16'h8001, 0, 0);
        do_read(1, 17'h1F00F, 16'h8001, "R9 bank1");
        do_read(0, 17'h1F00F, 16'hFFFF, "R9 bank0 untouched");
        do_prog(0, 17'h00200, 16'h7F7F, 20, 1);
        do_prog(0, 17'h04000, 16'h5555, 1, 0);
        do_erase(0, 17'h00123, 0, 5);
        do_read(0, 17'h00123, 16'hFFFF, "R6 sector cleared");
        do_read(0, 17'h00200, 16'hFFFF, "R6 sector cleared 2");
        do_read(0, 17'h04000, 16'h5555, "R6 other sector kept");
        do_erase(1, 17'h00000, 1, 2);
        do_read(1, 17'h1F00F, 16'hFFFF, "R6 bank erased");
        do_read(0, 17'h04000, 16'h5555, "R6 other bank kept");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule